// File: doc/BRIEF.md
# AXI to OCP Request Bridge

This block sits between an AXI master and a single OCP slave that share one clock. On the AXI side it accepts single-beat transfers on the write-address, write-data and read-address channels and answers on the write-response and read-data channels. On the OCP side it presents a request in which command, address and data all appear together, and it waits for the slave to take that request.

AXI delivers the write address and the write data on separate channels, in either order. OCP needs them in one request, so the bridge holds each half until the other has arrived. The read path and the write path each have their own small state machine. They share one OCP port, which carries one transaction at a time. When both paths are ready in the same cycle, a fairness flag decides which one goes first.

A static input selects how writes are issued. A write can be posted, in which case the AXI response follows as soon as the slave accepts the request. It can also be non-posted, in which case the AXI response waits for the slave's data-valid or error answer. Address and data widths are parameters.

Top module: `axi_ocp_bridge`

## Requirements
- R1: After reset, mCmd is 000, bValid and rValid are low, and awReady, wReady and arReady are high.
- R2: mCmd only ever carries 000 (idle), 001 (posted write), 010 (read) or 101 (non-posted write). It is 000 whenever no request is pending.
- R3: A write request is issued only after both the AXI write address and the AXI write data have been taken, whichever arrives first. In the same cycle as the command it carries mAddr equal to awAddr and mData equal to wData.
- R4: mCmd, mAddr and mData stay unchanged while sCmdAccept is low. After a rising edge with sCmdAccept high, mCmd returns to 000.
- R5: With cfgNonPost low, a write is sent as 001. bValid rises with bResp 00 (OKAY) in the cycle after acceptance, without waiting for sResp.
- R6: With cfgNonPost high at the moment of issue, a write is sent as 101 and bValid waits for sResp. An sResp of 01 (data valid) gives bResp 00, and an sResp of 11 (error) gives bResp 10 (SLVERR).
- R7: A read is sent as 010 with mAddr equal to arAddr. On sResp 01, rData takes sData and rResp is 00. On sResp 11, rResp is 10. sResp values 00 and 10 are ignored while a response is awaited.
- R8: bValid and bResp hold until bReady is seen high on an edge, and no new write address or data is taken meanwhile. rValid and rData hold until rReady is seen high on an edge, and arReady stays low meanwhile.
- R9: When a write and a read are both waiting for the OCP port, the path that was not granted last goes first. The write wins the first such contest after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cfgNonPost | input | 1 | 1: writes are issued as non-posted |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address ready |
| awAddr | input | ADDR_W | Write address |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data ready |
| wData | input | DATA_W | Write data |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response ready |
| bResp | output | 2 | Write response code |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address ready |
| arAddr | input | ADDR_W | Read address |
| rValid | output | 1 | Read data valid |
| rReady | input | 1 | Read data ready |
| rData | output | DATA_W | Read data |
| rResp | output | 2 | Read response code |
| mCmd | output | 3 | OCP command |
| mAddr | output | ADDR_W | OCP address |
| mData | output | DATA_W | OCP write data |
| sCmdAccept | input | 1 | OCP slave accepts the request |
| sResp | input | 2 | OCP slave response code |
| sData | input | DATA_W | OCP slave read data |

## Verification
The bench sends write data well ahead of the write address. A bridge that merged the halves too early would put a command with a stale address on OCP. The slave holds back sCmdAccept for several cycles, so a request that drifted or dropped back to idle too soon shows up. Null and fail response codes are placed before the real answer; a bridge that ended a read or a non-posted write on any nonzero code would raise its AXI response early. Simultaneous read and write arrivals are staged twice, once after a write and once after a read. A fixed-priority or stuck arbiter therefore issues in the wrong order in one of the two cases.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE   = 3'b000,
    CMD_WRITE  = 3'b001,
    CMD_READ   = 3'b010,
    CMD_WRNP   = 3'b101
  } ocpCmd_t;

  localparam logic [1:0] RESP_NULL = 2'b00;
  localparam logic [1:0] RESP_DVA  = 2'b01;
  localparam logic [1:0] RESP_ERR  = 2'b11;

  localparam logic [1:0] AXI_OKAY   = 2'b00;
  localparam logic [1:0] AXI_SLVERR = 2'b10;

  typedef struct packed {
    logic capAw;
    logic capW;
    logic capAr;
    logic capRd;
    logic loadBOk;
    logic loadBResp;
    logic selRd;
    logic drvWr;
  } dpStrobe_t;

endpackage

// File: rtl/bridge_dpath.sv
module bridge_dpath
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic [DATA_W-1:0] wData,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic [1:0]        sResp,
  input  logic [DATA_W-1:0] sData,
  output logic [ADDR_W-1:0] mAddr,
  output logic [DATA_W-1:0] mData,
  output logic [1:0]        bResp,
  output logic [DATA_W-1:0] rData,
  output logic [1:0]        rResp
);

  logic [ADDR_W-1:0] wrAddrQ;
  logic [ADDR_W-1:0] rdAddrQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [DATA_W-1:0] rdDataQ;
  logic [1:0]        bRespQ;
  logic [1:0]        rRespQ;
  logic [1:0]        mappedResp;

  // Error from slave becomes SLVERR, anything else accepted becomes OKAY
  assign mappedResp = (sResp == RESP_ERR) ? AXI_SLVERR : AXI_OKAY;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrAddrQ <= '0;
      rdAddrQ <= '0;
      wrDataQ <= '0;
      rdDataQ <= '0;
      bRespQ  <= AXI_OKAY;
      rRespQ  <= AXI_OKAY;
    end else begin
      if (stb.capAw)     wrAddrQ <= awAddr;
      if (stb.capW)      wrDataQ <= wData;
      if (stb.capAr)     rdAddrQ <= arAddr;
      if (stb.capRd) begin
        rdDataQ <= sData;
        rRespQ  <= mappedResp;
      end
      if (stb.loadBOk)   bRespQ <= AXI_OKAY;
      if (stb.loadBResp) bRespQ <= mappedResp;
    end
  end

  assign mAddr = stb.selRd ? rdAddrQ : wrAddrQ;
  assign mData = stb.drvWr ? wrDataQ : '0;
  assign bResp = bRespQ;
  assign rData = rdDataQ;
  assign rResp = rRespQ;

endmodule

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgNonPost,
  input  logic       awValid,
  input  logic       wValid,
  input  logic       bReady,
  input  logic       arValid,
  input  logic       rReady,
  input  logic       sCmdAccept,
  input  logic [1:0] sResp,
  output logic       awReady,
  output logic       wReady,
  output logic       bValid,
  output logic       arReady,
  output logic       rValid,
  output logic [2:0] mCmd,
  output dpStrobe_t  stb
);

  typedef enum logic [1:0] {WS_COLLECT, WS_PEND, WS_RESP} wrState_t;
  typedef enum logic [1:0] {RS_IDLE, RS_PEND, RS_RESP} rdState_t;
  typedef enum logic [2:0] {O_IDLE, O_WREQ, O_WWAIT, O_RREQ, O_RWAIT} ocpState_t;

  wrState_t  wrState, wrNext;
  rdState_t  rdState, rdNext;
  ocpState_t ocpState, ocpNext;

  logic haveAddr, haveData;
  logic haveAddrNext, haveDataNext;
  logic wrNonPost, wrNonPostNext;
  logic lastRd, lastRdNext;

  logic awFire, wFire, arFire, bFire, rFire;
  logic wrWants, rdWants, respDone;

  assign awReady = (wrState == WS_COLLECT) && !haveAddr;
  assign wReady  = (wrState == WS_COLLECT) && !haveData;
  assign bValid  = (wrState == WS_RESP);
  assign arReady = (rdState == RS_IDLE);
  assign rValid  = (rdState == RS_RESP);

  assign awFire = awValid && awReady;
  assign wFire  = wValid && wReady;
  assign arFire = arValid && arReady;
  assign bFire  = bValid && bReady;
  assign rFire  = rValid && rReady;

  assign wrWants  = (wrState == WS_PEND) && (ocpState == O_IDLE);
  assign rdWants  = (rdState == RS_PEND) && (ocpState == O_IDLE);
  assign respDone = (sResp == RESP_DVA) || (sResp == RESP_ERR);

  always_comb begin
    wrNext        = wrState;
    rdNext        = rdState;
    ocpNext       = ocpState;
    haveAddrNext  = haveAddr;
    haveDataNext  = haveData;
    wrNonPostNext = wrNonPost;
    lastRdNext    = lastRd;
    stb           = '0;

    // write collection: address and data may come in any order
    stb.capAw = awFire;
    stb.capW  = wFire;
    if (wrState == WS_COLLECT) begin
      haveAddrNext = haveAddr || awFire;
      haveDataNext = haveData || wFire;
      if (haveAddrNext && haveDataNext) begin
        wrNext       = WS_PEND;
        haveAddrNext = 1'b0;
        haveDataNext = 1'b0;
      end
    end
    if (wrState == WS_RESP && bFire) wrNext = WS_COLLECT;

    stb.capAr = arFire;
    if (arFire) rdNext = RS_PEND;
    if (rdState == RS_RESP && rFire) rdNext = RS_IDLE;

    // shared OCP port, one transaction at a time
    unique case (ocpState)
      O_IDLE: begin
        if (wrWants && (!rdWants || lastRd)) begin
          ocpNext       = O_WREQ;
          wrNonPostNext = cfgNonPost;
          lastRdNext    = 1'b0;
        end else if (rdWants) begin
          ocpNext    = O_RREQ;
          lastRdNext = 1'b1;
        end
      end
      O_WREQ: begin
        stb.drvWr = 1'b1;
        if (sCmdAccept) begin
          if (wrNonPost) begin
            ocpNext = O_WWAIT;
          end else begin
            ocpNext     = O_IDLE;
            wrNext      = WS_RESP;
            stb.loadBOk = 1'b1;
          end
        end
      end
      O_WWAIT: begin
        if (respDone) begin
          ocpNext       = O_IDLE;
          wrNext        = WS_RESP;
          stb.loadBResp = 1'b1;
        end
      end
      O_RREQ: begin
        stb.selRd = 1'b1;
        if (sCmdAccept) ocpNext = O_RWAIT;
      end
      O_RWAIT: begin
        stb.selRd = 1'b1;
        if (respDone) begin
          ocpNext   = O_IDLE;
          rdNext    = RS_RESP;
          stb.capRd = 1'b1;
        end
      end
      default: ocpNext = O_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrState   <= WS_COLLECT;
      rdState   <= RS_IDLE;
      ocpState  <= O_IDLE;
      haveAddr  <= 1'b0;
      haveData  <= 1'b0;
      wrNonPost <= 1'b0;
      lastRd    <= 1'b1;
    end else begin
      wrState   <= wrNext;
      rdState   <= rdNext;
      ocpState  <= ocpNext;
      haveAddr  <= haveAddrNext;
      haveData  <= haveDataNext;
      wrNonPost <= wrNonPostNext;
      lastRd    <= lastRdNext;
    end
  end

  always_comb begin
    unique case (ocpState)
      O_WREQ:  mCmd = wrNonPost ? CMD_WRNP : CMD_WRITE;
      O_RREQ:  mCmd = CMD_READ;
      default: mCmd = CMD_IDLE;
    endcase
  end

  p_cmd_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    (mCmd == CMD_IDLE) || (mCmd == CMD_WRITE) || (mCmd == CMD_READ) || (mCmd == CMD_WRNP));

  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mCmd != CMD_IDLE && !sCmdAccept) |=> $stable(mCmd));

  p_cmd_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mCmd != CMD_IDLE && sCmdAccept) |=> (mCmd == CMD_IDLE));

  p_b_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && !bReady) |=> bValid);

  p_r_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) |=> rValid);

  p_no_aw_in_b_r8: assert property (@(posedge clk) disable iff (!rstN)
    bValid |-> (!awReady && !wReady));

  p_no_ar_in_r_r8: assert property (@(posedge clk) disable iff (!rstN)
    rValid |-> !arReady);

endmodule

// File: rtl/axi_ocp_bridge.sv
module axi_ocp_bridge
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgNonPost,
  input  logic              awValid,
  output logic              awReady,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic              wValid,
  output logic              wReady,
  input  logic [DATA_W-1:0] wData,
  output logic              bValid,
  input  logic              bReady,
  output logic [1:0]        bResp,
  input  logic              arValid,
  output logic              arReady,
  input  logic [ADDR_W-1:0] arAddr,
  output logic              rValid,
  input  logic              rReady,
  output logic [DATA_W-1:0] rData,
  output logic [1:0]        rResp,
  output logic [2:0]        mCmd,
  output logic [ADDR_W-1:0] mAddr,
  output logic [DATA_W-1:0] mData,
  input  logic              sCmdAccept,
  input  logic [1:0]        sResp,
  input  logic [DATA_W-1:0] sData
);

  dpStrobe_t stb;

  bridge_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgNonPost (cfgNonPost),
    .awValid    (awValid),
    .wValid     (wValid),
    .bReady     (bReady),
    .arValid    (arValid),
    .rReady     (rReady),
    .sCmdAccept (sCmdAccept),
    .sResp      (sResp),
    .awReady    (awReady),
    .wReady     (wReady),
    .bValid     (bValid),
    .arReady    (arReady),
    .rValid     (rValid),
    .mCmd       (mCmd),
    .stb        (stb)
  );

  bridge_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .awAddr (awAddr),
    .wData  (wData),
    .arAddr (arAddr),
    .sResp  (sResp),
    .sData  (sData),
    .mAddr  (mAddr),
    .mData  (mData),
    .bResp  (bResp),
    .rData  (rData),
    .rResp  (rResp)
  );

  p_req_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mCmd != CMD_IDLE && !sCmdAccept) |=> ($stable(mAddr) && $stable(mData)));

  p_bresp_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && !bReady) |=> $stable(bResp));

  p_rdata_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) |=> ($stable(rData) && $stable(rResp)));

endmodule

// File: tb/tb_axi_ocp_bridge.sv
module tb_axi_ocp_bridge;

  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgNonPost = 1'b0;
  logic          awValid = 1'b0, wValid = 1'b0, bReady = 1'b0;
  logic          arValid = 1'b0, rReady = 1'b0;
  logic [AW-1:0] awAddr = '0, arAddr = '0;
  logic [DW-1:0] wData = '0, sData = '0;
  logic          sCmdAccept = 1'b0;
  logic [1:0]    sResp = 2'b00;
  logic          awReady, wReady, bValid, arReady, rValid;
  logic [1:0]    bResp, rResp;
  logic [DW-1:0] rData, mData;
  logic [AW-1:0] mAddr;
  logic [2:0]    mCmd;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  axi_ocp_bridge #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .cfgNonPost(cfgNonPost),
    .awValid(awValid), .awReady(awReady), .awAddr(awAddr),
    .wValid(wValid), .wReady(wReady), .wData(wData),
    .bValid(bValid), .bReady(bReady), .bResp(bResp),
    .arValid(arValid), .arReady(arReady), .arAddr(arAddr),
    .rValid(rValid), .rReady(rReady), .rData(rData), .rResp(rResp),
    .mCmd(mCmd), .mAddr(mAddr), .mData(mData),
    .sCmdAccept(sCmdAccept), .sResp(sResp), .sData(sData)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendAw(input logic [AW-1:0] a);
    @(negedge clk); awValid = 1'b1; awAddr = a;
    while (!awReady) @(negedge clk);
    @(negedge clk); awValid = 1'b0;
  endtask

  task automatic sendW(input logic [DW-1:0] d);
    @(negedge clk); wValid = 1'b1; wData = d;
    while (!wReady) @(negedge clk);
    @(negedge clk); wValid = 1'b0;
  endtask

  task automatic sendAr(input logic [AW-1:0] a);
    @(negedge clk); arValid = 1'b1; arAddr = a;
    while (!arReady) @(negedge clk);
    @(negedge clk); arValid = 1'b0;
  endtask

  // wait for a request, check it, hold it unaccepted, then accept
  task automatic ocpAccept(input logic [2:0] cmd, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input bit chkData, input int hold, input string tag);
    for (int i = 0; i < 30 && mCmd == 3'b000; i++) @(negedge clk);
    check(mCmd == cmd, {tag, " cmd"}, mCmd, cmd);
    check(mAddr == a, {tag, " addr"}, mAddr, a);
    if (chkData) check(mData == d, {tag, " data"}, mData, d);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(mCmd == cmd && mAddr == a, "R4 hold", {mCmd, mAddr}, {cmd, a});
    end
    sCmdAccept = 1'b1;
    @(negedge clk); sCmdAccept = 1'b0;
    check(mCmd == 3'b000, "R4 idle after accept", mCmd, 0);
  endtask

  // drive ignored codes for a while, then the final code
  task automatic ocpRespond(input logic [1:0] code, input logic [DW-1:0] d, input string tag);
    sResp = 2'b00;
    @(negedge clk);
    sResp = 2'b10;
    @(negedge clk);
    sResp = 2'b00;
    check(!bValid && !rValid, {tag, " R7 ignore null/fail"}, {bValid, rValid}, 0);
    sResp = code; sData = d;
    @(negedge clk); sResp = 2'b00; sData = '0;
  endtask

  task automatic takeB(input logic [1:0] exp, input string tag);
    check(bValid == 1'b1, {tag, " bValid"}, bValid, 1);
    check(bResp == exp, {tag, " bResp"}, bResp, exp);
    check(!awReady && !wReady, "R8 no AW/W during B", {awReady, wReady}, 0);
    @(negedge clk);
    @(negedge clk);
    check(bValid && bResp == exp, "R8 B held", {bValid, bResp}, {1'b1, exp});
    bReady = 1'b1;
    @(negedge clk); bReady = 1'b0;
    check(!bValid && awReady, "R8 B released", {bValid, awReady}, 2'b01);
  endtask

  task automatic takeR(input logic [1:0] exp, input logic [DW-1:0] d, input string tag);
    check(rValid == 1'b1, {tag, " rValid"}, rValid, 1);
    check(rResp == exp, {tag, " rResp"}, rResp, exp);
    if (exp == 2'b00) check(rData == d, {tag, " rData"}, rData, d);
    check(!arReady, "R8 no AR during R", arReady, 0);
    @(negedge clk);
    check(rValid && rData == d, "R8 R held", {rValid, rData}, {1'b1, d});
    rReady = 1'b1;
    @(negedge clk); rReady = 1'b0;
    check(!rValid && arReady, "R8 R released", {rValid, arReady}, 2'b01);
  endtask

  task automatic testReset();
    check(mCmd == 3'b000, "R1 mCmd", mCmd, 0);
    check(!bValid && !rValid, "R1 valids", {bValid, rValid}, 0);
    check(awReady && wReady && arReady, "R1 readies", {awReady, wReady, arReady}, 3'b111);
  endtask

  task automatic testPostedWrite();
    cfgNonPost = 1'b0;
    sendW(32'hCAFE_0001);
    repeat (4) @(negedge clk);
    check(mCmd == 3'b000, "R3 no request on data alone", mCmd, 0);
    check(!wReady && awReady, "R3 data held, address open", {wReady, awReady}, 2'b01);
    sendAw(32'h2000_0010);
    ocpAccept(3'b001, 32'h2000_0010, 32'hCAFE_0001, 1'b1, 3, "R3 R5 posted");
    takeB(2'b00, "R5");
  endtask

  task automatic testNonPostedWrite(input logic [1:0] code, input logic [1:0] exp, input string tag);
    cfgNonPost = 1'b1;
    fork
      sendAw(32'h4000_0020);
      sendW(32'h1234_5678);
    join
    ocpAccept(3'b101, 32'h4000_0020, 32'h1234_5678, 1'b1, 1, tag);
    cfgNonPost = 1'b0;
    check(!bValid, {tag, " B waits for response"}, bValid, 0);
    ocpRespond(code, '0, tag);
    takeB(exp, tag);
  endtask

  task automatic testRead(input logic [1:0] code, input logic [1:0] exp, input logic [DW-1:0] d, input string tag);
    sendAr(32'h8000_0044);
    ocpAccept(3'b010, 32'h8000_0044, '0, 1'b0, 2, tag);
    ocpRespond(code, d, tag);
    takeR(exp, d, tag);
  endtask

  task automatic both(input logic [DW-1:0] wd, input logic [DW-1:0] rd, input bit rdFirst, input string tag);
    cfgNonPost = 1'b0;
    fork
      sendAw(32'h0000_0100);
      sendW(wd);
      sendAr(32'h0000_0200);
    join
    if (rdFirst) begin
      ocpAccept(3'b010, 32'h0000_0200, '0, 1'b0, 0, {tag, " first read"});
      sResp = 2'b01; sData = rd;
      @(negedge clk); sResp = 2'b00;
      ocpAccept(3'b001, 32'h0000_0100, wd, 1'b1, 0, {tag, " then write"});
    end else begin
      ocpAccept(3'b001, 32'h0000_0100, wd, 1'b1, 0, {tag, " first write"});
      ocpAccept(3'b010, 32'h0000_0200, '0, 1'b0, 0, {tag, " then read"});
      sResp = 2'b01; sData = rd;
      @(negedge clk); sResp = 2'b00;
    end
    takeB(2'b00, tag);
    takeR(2'b00, rd, tag);
  endtask

  task automatic testArbitration();
    both(32'hA1, 32'hB1, 1'b0, "R9 reset winner write");
    // a lone write, then contest: read should win
    sendAw(32'h0000_0300); sendW(32'hC3);
    ocpAccept(3'b001, 32'h0000_0300, 32'hC3, 1'b1, 0, "R9 lone write");
    takeB(2'b00, "R9 lone write");
    both(32'hA2, 32'hB2, 1'b1, "R9 after write");
    // a lone read, then contest: write should win
    testRead(2'b01, 2'b00, 32'h55, "R9 lone read");
    both(32'hA3, 32'hB3, 1'b0, "R9 after read");
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPostedWrite();
    testNonPostedWrite(2'b01, 2'b00, "R6 dva");
    testNonPostedWrite(2'b11, 2'b10, "R6 err");
    testRead(2'b01, 2'b00, 32'hDEAD_BEEF, "R7 dva");
    testRead(2'b11, 2'b10, 32'h0, "R7 err");
    testArbitration();
    check(mCmd == 3'b000, "R2 idle at end", mCmd, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule